// File: doc/BRIEF.md
# Bidirectional Four-Mode Shift Register

A register of `WIDTH` stages (default 4) that, on each rising clock edge, holds its contents, shifts one place toward the high end, shifts one place toward the low end, or loads a parallel word. A 2-bit mode code selects the action. Stage A is bit 0 of `q_o` and the last stage (D at the default width) is bit `WIDTH-1`.

Two serial inputs feed the two ends. The right-shift input enters at stage A. The left-shift input enters at the last stage. This lets several registers be chained in either direction. An active-low clear empties every stage at once, without waiting for a clock edge. All stages are visible on `q_o` at all times.

Top module: `shreg_bidir`

## Requirements
- R1: While `rst_ni` is low, every bit of `q_o` is 0. The clear takes effect as soon as `rst_ni` falls, with no clock edge needed.
- R2: While `rst_ni` is low, rising clock edges leave `q_o` at 0 in every mode, including load.
- R3: Mode code `2'b00` (hold) leaves `q_o` unchanged across a rising edge.
- R4: Mode code `2'b01` (shift right) sets bit 0 to `ser_right_i` and bit i to the old bit i-1 for i ≥ 1.
- R5: Mode code `2'b10` (shift left) sets bit `WIDTH-1` to `ser_left_i` and bit i to the old bit i+1 for i < `WIDTH-1`.
- R6: Mode code `2'b11` (load) copies `par_i` into `q_o`, with bit i going to stage i.
- R7: Each unused input has no effect on the result. In shift right, `ser_left_i` and `par_i` are ignored. In shift left, `ser_right_i` and `par_i` are ignored. In hold and load, both serial inputs are ignored. In hold, `par_i` is also ignored.
- R8: `WIDTH` consecutive shifts in one direction with a constant serial input leave every stage equal to that input.
- R9: Inputs are sampled only at the rising edge. Changes to `mode_i` or to the data inputs between edges do not alter `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every mode action happens on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear |
| mode_i | input | 2 | Action select: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_right_i | input | 1 | Serial bit entering stage A on a right shift |
| ser_left_i | input | 1 | Serial bit entering the last stage on a left shift |
| par_i | input | WIDTH | Parallel word for load; bit 0 goes to stage A |
| q_o | output | WIDTH | Current contents of all stages |

## Verification
A mode action is due exactly one rising edge after it is applied. The bench drives each stimulus at a falling edge and compares `q_o` at the next falling edge. By then exactly one register stage lies between them.

The clear has no latency. It is checked one nanosecond after `rst_ni` falls in mid-cycle, before any edge arrives.

The insensitivity to changes between edges is checked a quarter period after the inputs change. The inputs are then set back before the edge.

The sweep starts from all 16 loaded values. For each, it applies all four modes with all four serial-input pairs, and uses the complement as the parallel word, so ignored inputs always differ from what a faulty path would pass.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  typedef struct packed {
    logic hold;
    logic shr;
    logic shl;
    logic load;
  } sel_t;
endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
  import shreg_pkg::*;
(
  input  logic [1:0] mode_i,
  output sel_t       sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (mode_i)
      MODE_SHR:  sel_o.shr  = 1'b1;
      MODE_SHL:  sel_o.shl  = 1'b1;
      MODE_LOAD: sel_o.load = 1'b1;
      default:   sel_o.hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
  import shreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  input  logic from_lo_i,  // neighbour toward stage A, or right serial in
  input  logic from_hi_i,  // neighbour toward last stage, or left serial in
  input  logic par_i,
  output logic q_o
);
  logic d;

  always_comb begin
    d = q_o;
    if (sel_i.shr)  d = from_lo_i;
    if (sel_i.shl)  d = from_hi_i;
    if (sel_i.load) d = par_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/shreg_bidir.sv
module shreg_bidir
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int MSB = WIDTH - 1;

  sel_t sel;

  shreg_mode_dec u_dec (
    .mode_i(mode_i),
    .sel_o (sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic lo, hi;
    if (i == 0) begin : g_lo_end
      assign lo = ser_right_i;
    end else begin : g_lo_mid
      assign lo = q_o[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign hi = ser_left_i;
    end else begin : g_hi_mid
      assign hi = q_o[i+1];
    end

    shreg_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel),
      .from_lo_i(lo),
      .from_hi_i(hi),
      .par_i    (par_i[i]),
      .q_o      (q_o[i])
    );
  end

  p_clear_r1: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == MODE_HOLD) |-> q_o == $past(q_o));

  p_shr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == MODE_SHR)
      |-> q_o == {$past(q_o[MSB-1:0]), $past(ser_right_i)});

  p_shl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == MODE_SHL)
      |-> q_o == {$past(ser_left_i), $past(q_o[MSB:1])});

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == MODE_LOAD) |-> q_o == $past(par_i));
endmodule

// File: tb/shreg_bidir_test.sv
module shreg_bidir_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         sr = 1'b0, sl = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] q;
  logic [W-1:0] exp_q = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  shreg_bidir #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .ser_right_i(sr), .ser_left_i(sl), .par_i(par), .q_o(q)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, got, want);
    end
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [1:0] m,
                                         logic r, logic l, logic [W-1:0] p);
    case (m)
      2'b01:   return {cur[W-2:0], r};
      2'b10:   return {l, cur[W-1:1]};
      2'b11:   return p;
      default: return cur;
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] m, input logic r, input logic l, input logic [W-1:0] p);
    mode = m; sr = r; sl = l; par = p;
    exp_q = model(exp_q, m, r, l, p);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset state", q, '0);
    mode = 2'b11; par = '1;
    @(posedge clk); @(negedge clk);
    chk("R2 load under clear", q, '0);
    rst_ni = 1'b1; mode = 2'b00;
    @(negedge clk);
    exp_q = '0;

    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int sv = 0; sv < 4; sv++) begin
          step(2'b11, sv[1], sv[0], W'(s));
          chk("R6 load", q, W'(s));
          step(2'(m), sv[0], sv[1], ~W'(s));
          case (m)
            0: chk("R3 hold, R7 unused inputs", q, exp_q);
            1: chk("R4 shift right, R7 unused inputs", q, exp_q);
            2: chk("R5 shift left, R7 unused inputs", q, exp_q);
            default: chk("R6 load complement", q, exp_q);
          endcase
        end
      end
    end

    step(2'b11, 1'b0, 1'b0, '0);
    for (int k = 0; k < W; k++) step(2'b01, 1'b1, 1'b0, '0);
    chk("R8 right fill ones", q, '1);
    for (int k = 0; k < W; k++) step(2'b10, 1'b1, 1'b0, '1);
    chk("R8 left fill zeros", q, '0);
    for (int k = 0; k < W; k++) step(2'b10, 1'b0, 1'b1, '0);
    chk("R8 left fill ones", q, '1);

    step(2'b11, 1'b0, 1'b0, 4'b1010);
    mode = 2'b11; par = 4'b0101; sr = 1'b1; sl = 1'b1;
    #5 chk("R9 no change between edges", q, 4'b1010);
    mode = 2'b00;
    @(posedge clk); @(negedge clk);
    chk("R3 hold after mid-cycle change", q, 4'b1010);

    step(2'b11, 1'b0, 1'b0, '1);
    #3 rst_ni = 1'b0;
    #1 chk("R1 async clear", q, '0);
    mode = 2'b11; par = '1;
    @(posedge clk); @(negedge clk);
    chk("R2 clock under clear", q, '0);
    rst_ni = 1'b1; exp_q = '0;
    step(2'b01, 1'b1, 1'b0, '0);
    chk("R4 shift after clear", q, 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule